// File: doc/BRIEF.md
# Prefix sequence decoder

This block is the byte-serial front end of an 8-bit processor core whose opcode map has two index-register prefixes (0xDD for index register X, 0xFD for index register Y), a bit/shift prefix (0xCB) and an extended prefix (0xED). A fetch unit presents one byte per `byte_valid` strobe. The bytes are prefix bytes, the opcode byte, and the signed displacement byte of indexed memory forms. Immediate and address bytes that follow an opcode are routed elsewhere by the fetch unit and are never strobed into this block.

When a sequence is complete, the block emits a one-cycle `done` pulse together with a decoded record. The record holds an operation group and a 3-bit sub-operation. It also holds the destination and source register selectors after index substitution, a flag for an indexed memory operand with its sign-extended displacement, the index register that stands in for the 16-bit HL pair, and an optional register that receives a copy of an indexed bit/shift result. Under an index prefix, the block models the less common behaviour of that prefix: bare H/L operands become the halves of the index register, H/L stay literal beside an indexed memory operand, and an indexed bit/shift result is copied into a register.

The state machine has these states:
- ST_IDLE: waiting for the first byte.
- ST_PFX: an index prefix has been seen.
- ST_MDISP: an indexed main-space opcode is waiting for its displacement.
- ST_XDISP: an indexed bit/shift form is waiting for its displacement.
- ST_XOP: an indexed bit/shift form is waiting for its operation byte.
- ST_CB: the plain bit/shift prefix has been seen.
- ST_ED: the extended prefix has been seen.

Transitions:
- ST_IDLE goes to ST_PFX on DD/FD, to ST_CB on CB, and to ST_ED on ED. Any other byte emits a record.
- ST_PFX stays in ST_PFX on DD/FD, emitting a no-op record for the discarded prefix. It goes to ST_XDISP on CB and to ST_ED on ED (the index is dropped). An opcode either goes to ST_MDISP or emits a record.
- ST_XDISP always goes to ST_XOP.
- ST_MDISP, ST_XOP, ST_CB and ST_ED each emit a record and return to ST_IDLE.

Top module: `opx_prefix_decoder`

## Requirements
- R1: While reset is held and right after it, `done` is 0 and the record is the idle record: group 0, aux 0, both selectors 15, `mem_indexed` 0, `idx_sel` 0, `copy_en` 0, `copy_sel` 0, `disp` 0.
- R2: Selector codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A, 8 X-high, 9 X-low, 10 Y-high, 11 Y-low, 12 immediate, 15 none. Group codes are 0 no-op, 1 8-bit load, 2 8-bit ALU, 3 inc/dec, 4 halt, 5 other main-space, 6 rotate/shift, 7 bit test, 8 bit reset, 9 bit set, 10 negate, 11 return-from-NMI, 12 return-from-interrupt, 13 interrupt mode, 14 other extended, 15 unassigned extended. Unprefixed 8-bit moves, ALU, inc/dec and immediate loads are decoded from fields op[5:3] and op[2:0]. For ALU forms, aux is op[5:3]; for inc/dec, aux is 0 for increment and 1 for decrement. Opcode 0x00 is a no-op.
- R3: After DD (`idx_sel` 1) or FD (`idx_sel` 2), a bare H or L operand of a form that has no memory operand becomes the high or low half of that index register.
- R4: After DD/FD, a memory operand becomes indexed (`mem_indexed` 1), H/L stay literal in that instruction, and the record is emitted only after the displacement byte that follows the opcode. Opcode 0x76 stays halt and takes no displacement.
- R5: `disp` is the displacement sign-extended to the output width, and is 0 when `mem_indexed` is 0.
- R6: The indexed bit/shift form is accepted in the order prefix, CB, displacement, operation byte. It acts on the indexed byte. When op[2:0] is not 6, `copy_en` is 1 and `copy_sel` is op[2:0] (literal register code).
- R7: After CB alone, the group comes from op[7:6] (rotate/shift, bit test, reset, set) and aux is op[5:3]. The operand is op[2:0]. Bit test has destination 15.
- R8: In the extended space, codes 0x44..0x7C with op[2:0]=4 decode as negate. Those with op[2:0]=5 decode as return-from-interrupt when op[3] is 1 and return-from-NMI otherwise. Those with op[2:0]=6 decode as interrupt mode with aux 0 for op[4:3]=0 or 1, aux 1 for op[4:3]=2, and aux 2 for op[4:3]=3.
- R9: Other extended codes with op[7:6]=1, or block codes (op[7:5]=5, op[2]=0), are group 14. Every remaining extended code is group 15. An ED after DD/FD clears the index (`idx_sel` 0).
- R10: A DD or FD arriving in ST_PFX emits a no-op record (idle record fields) for the discarded prefix, and the new prefix selects the index.
- R11: `done` pulses for exactly one cycle, one clock after the final byte of a sequence. Prefix and displacement bytes give no pulse. A byte with `byte_valid` low changes neither state nor record.
- R12: Every record decoded from the main space after DD/FD reports that index in `idx_sel`, so 16-bit HL forms use the full index register. Halt and other main-space codes follow the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Byte strobe |
| byte_in | input | 8 | Opcode, prefix or displacement byte |
| done | output | 1 | One-cycle pulse with a new record |
| grp | output | 4 | Operation group |
| aux | output | 3 | Sub-operation, bit number or mode |
| dst_sel | output | 4 | Destination selector |
| src_sel | output | 4 | Source selector |
| mem_indexed | output | 1 | Memory operand is index plus displacement |
| idx_sel | output | 2 | Index register in use (0 none, 1 X, 2 Y) |
| copy_en | output | 1 | Indexed bit/shift result also written to a register |
| copy_sel | output | 3 | Register code receiving the copy |
| disp | output | DISP_W | Sign-extended displacement |

## Verification
The bench builds the block with DISP_W at 16, so sign extension covers eight upper bits. Displacements 0x80 and 0xFE exercise the negative end, and a positive one checks zero fill. The default prefix byte parameters keep the real opcode map in play. That lets seeded random sequences reach every main, bit/shift, extended and indexed bit/shift code, next to directed prefix chains and idle-strobe cases.

// File: rtl/opx_pkg.sv
package opx_pkg;

    typedef enum logic [3:0] {
        G_NOP     = 4'd0,
        G_LD8     = 4'd1,
        G_ALU8    = 4'd2,
        G_INCDEC  = 4'd3,
        G_HALT    = 4'd4,
        G_MISC    = 4'd5,
        G_ROT     = 4'd6,
        G_BITT    = 4'd7,
        G_BITR    = 4'd8,
        G_BITS    = 4'd9,
        G_NEGATE  = 4'd10,
        G_RET_NMI = 4'd11,
        G_RET_INT = 4'd12,
        G_INTMODE = 4'd13,
        G_EXT_MSC = 4'd14,
        G_EXT_NONE= 4'd15
    } grp_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PFX, ST_MDISP, ST_XDISP, ST_XOP, ST_CB, ST_ED
    } st_e;

    localparam logic [3:0] SEL_MEM  = 4'd6;
    localparam logic [3:0] SEL_A    = 4'd7;
    localparam logic [3:0] SEL_IMM  = 4'd12;
    localparam logic [3:0] SEL_NONE = 4'd15;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] aux;
        logic [3:0] dst;
        logic [3:0] src;
        logic       mem;
        logic [1:0] idx;
        logic       cen;
        logic [2:0] csel;
        logic [7:0] disp8;
    } rec_t;

    localparam rec_t REC_IDLE = '{grp: G_NOP, aux: 3'd0, dst: SEL_NONE,
                                  src: SEL_NONE, mem: 1'b0, idx: 2'd0,
                                  cen: 1'b0, csel: 3'd0, disp8: 8'd0};

    // Replace a bare H/L register code by an index half when an index is active.
    function automatic logic [3:0] sel_sub(input logic [2:0] code,
                                           input logic [1:0] idx);
        logic [3:0] base;
        base = (idx == 2'd2) ? 4'd10 : 4'd8;
        if (idx != 2'd0 && code == 3'd4) return base;
        if (idx != 2'd0 && code == 3'd5) return base + 4'd1;
        return {1'b0, code};
    endfunction

endpackage

// File: rtl/opx_main_dec.sv
module opx_main_dec
    import opx_pkg::*;
(
    input  logic [7:0] op,
    input  logic [1:0] idx,
    output rec_t       rec,
    output logic       need_disp
);
    logic [1:0] fx;
    logic [2:0] fy;
    logic [2:0] fz;
    logic       mem;

    assign fx = op[7:6];
    assign fy = op[5:3];
    assign fz = op[2:0];

    always_comb begin
        rec     = REC_IDLE;
        rec.grp = G_MISC;
        rec.idx = idx;
        mem     = 1'b0;
        if (op == 8'h00) begin
            rec.grp = G_NOP;
        end else if (op == 8'h76) begin
            rec.grp = G_HALT;
        end else begin
            unique case (fx)
                2'd1: begin
                    rec.grp = G_LD8;
                    mem     = (fy == 3'd6) || (fz == 3'd6);
                    if (mem) begin
                        rec.dst = {1'b0, fy};
                        rec.src = {1'b0, fz};
                    end else begin
                        rec.dst = sel_sub(fy, idx);
                        rec.src = sel_sub(fz, idx);
                    end
                end
                2'd2: begin
                    rec.grp = G_ALU8;
                    rec.aux = fy;
                    rec.dst = SEL_A;
                    mem     = (fz == 3'd6);
                    rec.src = mem ? SEL_MEM : sel_sub(fz, idx);
                end
                2'd0: begin
                    if (fz == 3'd4 || fz == 3'd5) begin
                        rec.grp = G_INCDEC;
                        rec.aux = {2'b00, fz[0]};
                        mem     = (fy == 3'd6);
                        rec.dst = mem ? SEL_MEM : sel_sub(fy, idx);
                        rec.src = rec.dst;
                    end else if (fz == 3'd6) begin
                        rec.grp = G_LD8;
                        mem     = (fy == 3'd6);
                        rec.dst = mem ? SEL_MEM : sel_sub(fy, idx);
                        rec.src = SEL_IMM;
                    end
                end
                2'd3: begin
                    if (fz == 3'd6) begin
                        rec.grp = G_ALU8;
                        rec.aux = fy;
                        rec.dst = SEL_A;
                        rec.src = SEL_IMM;
                    end
                end
                default: ;
            endcase
        end
        rec.mem   = mem && (idx != 2'd0);
        need_disp = rec.mem;
    end
endmodule

// File: rtl/opx_cb_dec.sv
module opx_cb_dec
    import opx_pkg::*;
(
    input  logic [7:0] op,
    input  logic       indexed,
    input  logic [1:0] idx,
    input  logic [7:0] disp8,
    output rec_t       rec
);
    logic [2:0] fz;
    assign fz = op[2:0];

    always_comb begin
        rec     = REC_IDLE;
        rec.aux = op[5:3];
        unique case (op[7:6])
            2'd0: rec.grp = G_ROT;
            2'd1: rec.grp = G_BITT;
            2'd2: rec.grp = G_BITR;
            default: rec.grp = G_BITS;
        endcase
        if (indexed) begin
            rec.src   = SEL_MEM;
            rec.dst   = (op[7:6] == 2'd1) ? SEL_NONE : SEL_MEM;
            rec.mem   = 1'b1;
            rec.idx   = idx;
            rec.cen   = (fz != 3'd6);
            rec.csel  = (fz != 3'd6) ? fz : 3'd0;
            rec.disp8 = disp8;
        end else begin
            rec.src = {1'b0, fz};
            rec.dst = (op[7:6] == 2'd1) ? SEL_NONE : {1'b0, fz};
        end
    end
endmodule

// File: rtl/opx_ed_dec.sv
module opx_ed_dec
    import opx_pkg::*;
(
    input  logic [7:0] op,
    output rec_t       rec
);
    always_comb begin
        rec     = REC_IDLE;
        rec.grp = G_EXT_NONE;
        if (op[7:6] == 2'd1) begin
            unique case (op[2:0])
                3'd4: rec.grp = G_NEGATE;
                3'd5: rec.grp = op[3] ? G_RET_INT : G_RET_NMI;
                3'd6: begin
                    rec.grp = G_INTMODE;
                    unique case (op[4:3])
                        2'd2:    rec.aux = 3'd1;
                        2'd3:    rec.aux = 3'd2;
                        default: rec.aux = 3'd0;
                    endcase
                end
                default: rec.grp = G_EXT_MSC;
            endcase
        end else if (op[7:5] == 3'b101 && !op[2]) begin
            rec.grp = G_EXT_MSC;
        end
    end
endmodule

// File: rtl/opx_prefix_decoder.sv
module opx_prefix_decoder
    import opx_pkg::*;
#(
    parameter int          DISP_W  = 16,
    parameter logic [7:0]  PFX_X   = 8'hDD,
    parameter logic [7:0]  PFX_Y   = 8'hFD,
    parameter logic [7:0]  PFX_BIT = 8'hCB,
    parameter logic [7:0]  PFX_EXT = 8'hED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    output logic              done,
    output logic [3:0]        grp,
    output logic [2:0]        aux,
    output logic [3:0]        dst_sel,
    output logic [3:0]        src_sel,
    output logic              mem_indexed,
    output logic [1:0]        idx_sel,
    output logic              copy_en,
    output logic [2:0]        copy_sel,
    output logic [DISP_W-1:0] disp
);
    localparam int EXT_W = DISP_W - 8;

    st_e        st_q, st_d;
    logic [1:0] idx_q, idx_d;
    logic [7:0] dsp_q, dsp_d;
    rec_t       pend_q, pend_d;
    rec_t       rec_q, emit_rec;
    logic       done_q, emit;

    rec_t       main_rec, cb_rec, ed_rec;
    logic       main_need;
    logic [1:0] main_idx;
    logic       is_idx_pfx;
    logic [1:0] pfx_code;

    assign main_idx   = (st_q == ST_PFX) ? idx_q : 2'd0;
    assign is_idx_pfx = (byte_in == PFX_X) || (byte_in == PFX_Y);
    assign pfx_code   = (byte_in == PFX_Y) ? 2'd2 : 2'd1;

    opx_main_dec u_main (
        .op        (byte_in),
        .idx       (main_idx),
        .rec       (main_rec),
        .need_disp (main_need)
    );

    opx_cb_dec u_cb (
        .op      (byte_in),
        .indexed (st_q == ST_XOP),
        .idx     (idx_q),
        .disp8   (dsp_q),
        .rec     (cb_rec)
    );

    opx_ed_dec u_ed (
        .op  (byte_in),
        .rec (ed_rec)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= 2'd0;
            dsp_q  <= 8'd0;
            pend_q <= REC_IDLE;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            dsp_q  <= dsp_d;
            pend_q <= pend_d;
        end
    end

    // Next state and record selection
    always_comb begin
        st_d     = st_q;
        idx_d    = idx_q;
        dsp_d    = dsp_q;
        pend_d   = pend_q;
        emit     = 1'b0;
        emit_rec = REC_IDLE;
        if (byte_valid) begin
            unique case (st_q)
                ST_IDLE, ST_PFX: begin
                    if (is_idx_pfx) begin
                        emit  = (st_q == ST_PFX);
                        idx_d = pfx_code;
                        st_d  = ST_PFX;
                    end else if (byte_in == PFX_BIT) begin
                        st_d  = (st_q == ST_PFX) ? ST_XDISP : ST_CB;
                    end else if (byte_in == PFX_EXT) begin
                        idx_d = 2'd0;
                        st_d  = ST_ED;
                    end else if (main_need) begin
                        pend_d = main_rec;
                        st_d   = ST_MDISP;
                    end else begin
                        emit     = 1'b1;
                        emit_rec = main_rec;
                        idx_d    = 2'd0;
                        st_d     = ST_IDLE;
                    end
                end
                ST_MDISP: begin
                    emit           = 1'b1;
                    emit_rec       = pend_q;
                    // The pending slot holds a zero displacement field.
                    emit_rec.disp8 = pend_q.disp8 | byte_in;
                    idx_d          = 2'd0;
                    st_d           = ST_IDLE;
                end
                ST_XDISP: begin
                    dsp_d = byte_in;
                    st_d  = ST_XOP;
                end
                ST_XOP, ST_CB: begin
                    emit     = 1'b1;
                    emit_rec = cb_rec;
                    idx_d    = 2'd0;
                    st_d     = ST_IDLE;
                end
                ST_ED: begin
                    emit     = 1'b1;
                    emit_rec = ed_rec;
                    st_d     = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Output record register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rec_q  <= REC_IDLE;
        end else begin
            done_q <= emit;
            if (emit) rec_q <= emit_rec;
        end
    end

    assign done        = done_q;
    assign grp         = rec_q.grp;
    assign aux         = rec_q.aux;
    assign dst_sel     = rec_q.dst;
    assign src_sel     = rec_q.src;
    assign mem_indexed = rec_q.mem;
    assign idx_sel     = rec_q.idx;
    assign copy_en     = rec_q.cen;
    assign copy_sel    = rec_q.csel;

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp = {{EXT_W{rec_q.disp8[7]}}, rec_q.disp8};
        end else begin : g_trunc
            assign disp = rec_q.disp8[DISP_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/opx_prefix_checker.sv
module opx_prefix_checker #(
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              done,
    input logic [3:0]        grp,
    input logic [3:0]        dst_sel,
    input logic [3:0]        src_sel,
    input logic              mem_indexed,
    input logic [1:0]        idx_sel,
    input logic              copy_en,
    input logic [DISP_W-1:0] disp
);
    assert_copy_only_indexed_cb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && copy_en) |-> (mem_indexed && grp >= 4'd6 && grp <= 4'd9));

    assert_no_half_with_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_indexed) |-> !(dst_sel inside {[4'd8:4'd11]}) && !(src_sel inside {[4'd8:4'd11]}));

    assert_mem_has_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_indexed) |-> (idx_sel != 2'd0));

    assert_disp_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp[DISP_W-1:7] == {(DISP_W-7){disp[7]}}));

    assert_disp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mem_indexed) |-> (disp == '0));

    assert_done_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_valid));

    assert_ext_no_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grp >= 4'd10) |-> (idx_sel == 2'd0));
endmodule

bind opx_prefix_decoder opx_prefix_checker #(.DISP_W(DISP_W)) u_opx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .done        (done),
    .grp         (grp),
    .dst_sel     (dst_sel),
    .src_sel     (src_sel),
    .mem_indexed (mem_indexed),
    .idx_sel     (idx_sel),
    .copy_en     (copy_en),
    .disp        (disp)
);

// File: tb/opx_prefix_decoder_bench.sv
module opx_prefix_decoder_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          done;
    logic [3:0]    grp, dst_sel, src_sel;
    logic [2:0]    aux, copy_sel;
    logic          mem_indexed, copy_en;
    logic [1:0]    idx_sel;
    logic [DW-1:0] disp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    opx_prefix_decoder #(.DISP_W(DW)) u_opx_prefix_decoder (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .done(done), .grp(grp), .aux(aux), .dst_sel(dst_sel), .src_sel(src_sel),
        .mem_indexed(mem_indexed), .idx_sel(idx_sel), .copy_en(copy_en),
        .copy_sel(copy_sel), .disp(disp)
    );

    function automatic logic [37:0] mk(input logic [3:0] g, input logic [2:0] a,
        input logic [3:0] d, input logic [3:0] s, input logic m, input logic [1:0] ix,
        input logic ce, input logic [2:0] cs, input logic [15:0] dp);
        return {g, a, d, s, m, ix, ce, cs, dp};
    endfunction

    function automatic logic [37:0] idle_rec();
        return mk(4'd0, 3'd0, 4'd15, 4'd15, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000);
    endfunction

    function automatic logic [15:0] sx(input logic [7:0] d);
        return {{8{d[7]}}, d};
    endfunction

    function automatic logic [3:0] bsub(input logic [2:0] c, input logic [1:0] ix);
        if (ix == 2'd1 && c == 3'd4) return 4'd8;
        if (ix == 2'd1 && c == 3'd5) return 4'd9;
        if (ix == 2'd2 && c == 3'd4) return 4'd10;
        if (ix == 2'd2 && c == 3'd5) return 4'd11;
        return {1'b0, c};
    endfunction

    function automatic bit is_pfx(input logic [7:0] b);
        return b == 8'hCB || b == 8'hDD || b == 8'hED || b == 8'hFD;
    endfunction

    // Expected main-space record (R2, R3, R4, R12)
    function automatic logic [37:0] exp_main(input logic [7:0] op, input logic [1:0] ix,
                                             input logic [7:0] d, output bit need);
        logic [3:0] g, ds, ss;
        logic [2:0] a;
        bit m;
        g = 4'd5; a = 3'd0; ds = 4'd15; ss = 4'd15; m = 0;
        if (op == 8'h00) g = 4'd0;
        else if (op == 8'h76) g = 4'd4;
        else if (op[7:6] == 2'd1) begin
            g = 4'd1;
            m = (op[5:3] == 3'd6) || (op[2:0] == 3'd6);
            ds = m ? {1'b0, op[5:3]} : bsub(op[5:3], ix);
            ss = m ? {1'b0, op[2:0]} : bsub(op[2:0], ix);
        end else if (op[7:6] == 2'd2) begin
            g = 4'd2; a = op[5:3]; ds = 4'd7;
            m = (op[2:0] == 3'd6);
            ss = m ? 4'd6 : bsub(op[2:0], ix);
        end else if (op[7:6] == 2'd0 && (op[2:0] == 3'd4 || op[2:0] == 3'd5)) begin
            g = 4'd3; a = (op[2:0] == 3'd5) ? 3'd1 : 3'd0;
            m = (op[5:3] == 3'd6);
            ds = m ? 4'd6 : bsub(op[5:3], ix); ss = ds;
        end else if (op[7:6] == 2'd0 && op[2:0] == 3'd6) begin
            g = 4'd1; m = (op[5:3] == 3'd6);
            ds = m ? 4'd6 : bsub(op[5:3], ix); ss = 4'd12;
        end else if (op[7:6] == 2'd3 && op[2:0] == 3'd6) begin
            g = 4'd2; a = op[5:3]; ds = 4'd7; ss = 4'd12;
        end
        need = m && (ix != 2'd0);
        return mk(g, a, ds, ss, need, ix, 1'b0, 3'd0, need ? sx(d) : 16'h0000);
    endfunction

    // Expected bit/shift record (R6, R7)
    function automatic logic [37:0] exp_cb(input logic [7:0] op, input logic [1:0] ix,
                                           input logic [7:0] d);
        logic [3:0] g;
        g = 4'd6 + {2'b00, op[7:6]};
        if (ix == 2'd0)
            return mk(g, op[5:3], (op[7:6] == 2'd1) ? 4'd15 : {1'b0, op[2:0]},
                      {1'b0, op[2:0]}, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000);
        return mk(g, op[5:3], (op[7:6] == 2'd1) ? 4'd15 : 4'd6, 4'd6, 1'b1, ix,
                  op[2:0] != 3'd6, (op[2:0] != 3'd6) ? op[2:0] : 3'd0, sx(d));
    endfunction

    // Expected extended record (R8, R9)
    function automatic logic [37:0] exp_ed(input logic [7:0] op);
        logic [3:0] g;
        logic [2:0] a;
        g = 4'd15; a = 3'd0;
        if (op[7:6] == 2'd1) begin
            case (op[2:0])
                3'd4: g = 4'd10;
                3'd5: g = op[3] ? 4'd12 : 4'd11;
                3'd6: begin
                    g = 4'd13;
                    a = (op[4:3] == 2'd2) ? 3'd1 : (op[4:3] == 2'd3) ? 3'd2 : 3'd0;
                end
                default: g = 4'd14;
            endcase
        end else if (op[7:5] == 3'b101 && op[2] == 1'b0) g = 4'd14;
        return mk(g, a, 4'd15, 4'd15, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000);
    endfunction

    function automatic logic [37:0] dut_rec();
        return {grp, aux, dst_sel, src_sel, mem_indexed, idx_sel, copy_en, copy_sel, disp};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [37:0] act,
                         input logic [37:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // Sends n bytes; no pulse before the last, pulse and record after it.
    task automatic send_seq(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3, input int n,
                            input logic [37:0] expv, input string tag);
        logic [7:0] bs [4];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        for (int i = 0; i < n; i++) begin
            send_byte(bs[i]);
            if (i < n - 1) check(done == 1'b0, "R11 pulse on inner byte", {37'd0, done}, 38'd0);
        end
        check(done == 1'b1, {tag, " done"}, {37'd0, done}, 38'd1);
        check(dut_rec() == expv, tag, dut_rec(), expv);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [37:0] e;
        bit nd;
        void'($urandom(32'h0D1C_5EED));
        repeat (3) @(negedge clk);
        check(done == 1'b0 && dut_rec() == idle_rec(), "R1 in reset", dut_rec(), idle_rec());
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && dut_rec() == idle_rec(), "R1 after reset", dut_rec(), idle_rec());

        // R2 plain forms
        send_seq(8'h78, 0, 0, 0, 1, mk(4'd1, 3'd0, 4'd7, 4'd0, 0, 2'd0, 0, 3'd0, 16'h0), "R2 load A from B");
        send_seq(8'h91, 0, 0, 0, 1, mk(4'd2, 3'd2, 4'd7, 4'd1, 0, 2'd0, 0, 3'd0, 16'h0), "R2 subtract C");
        send_seq(8'h35, 0, 0, 0, 1, mk(4'd3, 3'd1, 4'd6, 4'd6, 0, 2'd0, 0, 3'd0, 16'h0), "R2 dec memory");
        // R3 index halves
        send_seq(8'hDD, 8'h44, 0, 0, 2, mk(4'd1, 3'd0, 4'd0, 4'd8, 0, 2'd1, 0, 3'd0, 16'h0), "R3 B from X-high");
        send_seq(8'hFD, 8'h65, 0, 0, 2, mk(4'd1, 3'd0, 4'd10, 4'd11, 0, 2'd2, 0, 3'd0, 16'h0), "R3 Y-high from Y-low");
        send_seq(8'hDD, 8'h24, 0, 0, 2, mk(4'd3, 3'd0, 4'd8, 4'd8, 0, 2'd1, 0, 3'd0, 16'h0), "R3 inc X-high");
        // R4 / R5 indexed memory
        send_seq(8'hDD, 8'h66, 8'h05, 0, 3, mk(4'd1, 3'd0, 4'd4, 4'd6, 1, 2'd1, 0, 3'd0, 16'h0005), "R4 literal H from indexed");
        send_seq(8'hDD, 8'h74, 8'hFE, 0, 3, mk(4'd1, 3'd0, 4'd6, 4'd4, 1, 2'd1, 0, 3'd0, 16'hFFFE), "R5 negative disp");
        send_seq(8'hDD, 8'h76, 0, 0, 2, mk(4'd4, 3'd0, 4'd15, 4'd15, 0, 2'd1, 0, 3'd0, 16'h0), "R4 halt under prefix");
        // R6 indexed bit/shift
        send_seq(8'hFD, 8'hCB, 8'h80, 8'h86, 4, mk(4'd8, 3'd0, 4'd6, 4'd6, 1, 2'd2, 0, 3'd0, 16'hFF80), "R6 reset bit on memory only");
        send_seq(8'hFD, 8'hCB, 8'h03, 8'h10, 4, mk(4'd6, 3'd2, 4'd6, 4'd6, 1, 2'd2, 1, 3'd0, 16'h0003), "R6 rotate copy to B");
        send_seq(8'hDD, 8'hCB, 8'h7F, 8'hFC, 4, mk(4'd9, 3'd7, 4'd6, 4'd6, 1, 2'd1, 1, 3'd4, 16'h007F), "R6 set copy to literal H");
        // R7 plain bit/shift
        send_seq(8'hCB, 8'h3F, 0, 0, 2, mk(4'd6, 3'd7, 4'd7, 4'd7, 0, 2'd0, 0, 3'd0, 16'h0), "R7 shift A");
        send_seq(8'hCB, 8'h46, 0, 0, 2, mk(4'd7, 3'd0, 4'd15, 4'd6, 0, 2'd0, 0, 3'd0, 16'h0), "R7 bit test memory");
        // R8 / R9 extended
        send_seq(8'hED, 8'h7C, 0, 0, 2, mk(4'd10, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 negate alias");
        send_seq(8'hED, 8'h5D, 0, 0, 2, mk(4'd12, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 return int alias");
        send_seq(8'hED, 8'h65, 0, 0, 2, mk(4'd11, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 return nmi alias");
        send_seq(8'hED, 8'h5E, 0, 0, 2, mk(4'd13, 3'd2, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 mode 2");
        send_seq(8'hED, 8'h66, 0, 0, 2, mk(4'd13, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 mode 0 alias");
        send_seq(8'hED, 8'h76, 0, 0, 2, mk(4'd13, 3'd1, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R8 mode 1 alias");
        send_seq(8'hED, 8'h00, 0, 0, 2, mk(4'd15, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R9 unassigned");
        send_seq(8'hED, 8'hB0, 0, 0, 2, mk(4'd14, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R9 block op");
        send_seq(8'hDD, 8'hED, 8'h44, 0, 3, mk(4'd10, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R9 index dropped");
        // R10 prefix chain
        send_byte(8'hDD);
        check(done == 1'b0, "R10 first prefix", {37'd0, done}, 38'd0);
        send_seq(8'hFD, 0, 0, 0, 1, idle_rec(), "R10 discarded prefix record");
        send_seq(8'h44, 0, 0, 0, 1, mk(4'd1, 3'd0, 4'd0, 4'd10, 0, 2'd2, 0, 3'd0, 16'h0), "R10 later prefix wins");
        // R12 16-bit forms
        send_seq(8'hDD, 8'h21, 0, 0, 2, mk(4'd5, 3'd0, 4'd15, 4'd15, 0, 2'd1, 0, 3'd0, 16'h0), "R12 pair load uses X");
        send_seq(8'hE9, 0, 0, 0, 1, mk(4'd5, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0), "R12 plain jump");
        // R11 strobe low ignored
        e = mk(4'd5, 3'd0, 4'd15, 4'd15, 0, 2'd0, 0, 3'd0, 16'h0);
        byte_in = 8'hDD;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(done == 1'b0 && dut_rec() == e, "R11 idle strobe", dut_rec(), e);
        end
        send_seq(8'h78, 0, 0, 0, 1, mk(4'd1, 3'd0, 4'd7, 4'd0, 0, 2'd0, 0, 3'd0, 16'h0), "R11 no state from low strobe");

        // Seeded random sequences
        for (int t = 0; t < 600; t++) begin
            logic [7:0] op, d, pf;
            int kind;
            kind = $urandom % 5;
            op = 8'($urandom); d = 8'($urandom);
            pf = ($urandom % 2) ? 8'hDD : 8'hFD;
            case (kind)
                0: begin
                    while (is_pfx(op)) op = 8'($urandom);
                    e = exp_main(op, 2'd0, d, nd);
                    send_seq(op, 0, 0, 0, 1, e, "R2 random plain");
                end
                1: send_seq(8'hCB, op, 0, 0, 2, exp_cb(op, 2'd0, d), "R7 random bit/shift");
                2: send_seq(8'hED, op, 0, 0, 2, exp_ed(op), "R8 random extended");
                3: begin
                    while (is_pfx(op)) op = 8'($urandom);
                    e = exp_main(op, (pf == 8'hDD) ? 2'd1 : 2'd2, d, nd);
                    if (nd) send_seq(pf, op, d, 0, 3, e, "R4 random indexed memory");
                    else    send_seq(pf, op, 0, 0, 2, e, "R3 random indexed");
                end
                default: send_seq(pf, 8'hCB, d, op, 4,
                                  exp_cb(op, (pf == 8'hDD) ? 2'd1 : 2'd2, d), "R6 random indexed bit/shift");
            endcase
            if ($urandom % 4 == 0) begin
                byte_in = 8'($urandom);
                @(negedge clk);
                check(done == 1'b0, "R11 random gap", {37'd0, done}, 38'd0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule